// File: doc/BRIEF.md
# Scaled Fixed-Point Integrator with Pulse-Rate Output

This block is a single hardware integration stage for solving ordinary differential equations. While it is running, it takes one signed input sample on every rising clock edge, multiplies the sample by a host-programmed fraction K (0 <= K < 1), and adds the product to a fixed-point running value. That running value is an integer part (the integral) plus a fractional residue. The residue keeps every sub-LSB contribution, so the only error left is the finite width of the registers. Each change of the integer part is also shown as an output pulse, so the integral can be read as a pulse rate as well as a number.

A host drives a simple 32-bit register port on the same clock as the datapath. It writes K, an initial value and a step target. It then loads the initial condition, enables integration and reads the integral back. After the programmed number of steps the block raises a sticky result-valid flag and an interrupt line. The host acknowledges that interrupt with a clear strobe. The integer part saturates at its signed limits instead of wrapping, and a sticky overflow flag records that a limit was hit.

Top module: `dda_integrator`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and pulse_o, pulse_dn_o and irq_o are low.
- R2: While enabled (control bit0 = 1), each clock edge adds K*S to the value I*2^FRAC_W + F. Here I is the signed integral, F is the unsigned FRAC_W-bit residue, K is the low FRAC_W bits of register 0x4 taken as an unsigned fraction, and S is the signed sample. I is the floor of that value divided by 2^FRAC_W. Address 0xC returns I sign-extended to 32 bits, visible from the edge that performed the step.
- R3: Writing control bit1 = 1 copies the initial value (register 0x8, low ACC_W bits, signed) into I, zeroes F, the step count, the valid flag and the overflow flag. This load wins over a step at the same edge, and bit1 always reads back as 0.
- R4: While control bit0 = 0, I and F do not change, whatever the sample input does, and no pulse appears.
- R5: pulse_o is high for the one cycle after each step that changed I. pulse_dn_o is high in that cycle only when I decreased. When |K*S| < 1, each pulse stands for exactly one LSB.
- R6: When a step would take I above 2^(ACC_W-1)-1 or below -2^(ACC_W-1), I is held at that limit and F keeps its previous value. Status bit1 (address 0x10) then becomes 1 and stays 1 until the next load.
- R7: The step target is the low STEP_W bits of register 0x14. When the number of steps counted since the last load or the last target hit reaches a nonzero target, status bit0 and irq_o go high and the count restarts from 0. A target of 0 never raises them.
- R8: Writing control bit2 = 1 clears status bit0 and irq_o. If a target hit happens at the same edge, the flag stays set.
- R9: Addresses 0x0 (bit0), 0x4, 0x8 (sign-extended) and 0x14 read back the written fields. Bits above each field, and any other address (including unaligned ones), read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the datapath and the register port |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed input sample S |
| reg_addr | input | ADDR_W | Byte address for register read and write |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pulse_o | output | 1 | One-cycle pulse for each change of the integral |
| pulse_dn_o | output | 1 | Marks a pulse as a decrease |
| irq_o | output | 1 | Result-valid interrupt, high until cleared |

## Verification
A residue that is dropped or mis-carried leaves the integral one LSB off within a few steps at small K. That error then shows up at once at address 0xC and as a missing or extra pulse on pulse_o in the very next cycle. Saturation faults show on the first step past a limit, as a wrapped integral or a missing overflow bit. A miscount of steps moves the rising edge of irq_o by at least one cycle against the arithmetic target. The bench sweeps every sample value of a narrow configuration against a set of coefficients and compares each cycle with a model built from the formulas above, so such faults appear at the cycle they occur.

// File: rtl/dda_pkg.sv
`timescale 1ns/1ps
// Package dda_pkg
// Shared register addresses, control and status bit positions, and the
// decoded host command type of the integrator.
package dda_pkg;
    localparam int ADR_CTRL   = 'h00;
    localparam int ADR_COEF   = 'h04;
    localparam int ADR_INIT   = 'h08;
    localparam int ADR_RESULT = 'h0C;
    localparam int ADR_STATUS = 'h10;
    localparam int ADR_TARGET = 'h14;

    localparam int CB_RUN   = 0;
    localparam int CB_LOAD  = 1;
    localparam int CB_ACK   = 2;

    localparam int SB_VALID = 0;
    localparam int SB_OVF   = 1;

    typedef struct packed {
        logic run;
        logic load;
        logic ack;
    } host_cmd_t;
endpackage

// File: rtl/dda_regs.sv
`timescale 1ns/1ps
// Module dda_regs
// Host register file. It holds the run bit, coefficient, initial value and
// step target, decodes the load and acknowledge strobes, and muxes read data.
// Assumes one access per cycle on the common clock and fields of at most 32 bits.
module dda_regs
    import dda_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int FRAC_W = 16,
    parameter int ACC_W  = 32,
    parameter int STEP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_en_i,
    input  logic [31:0]              wdata_i,
    output logic [31:0]              rdata_o,
    input  logic signed [ACC_W-1:0]  integral_i,
    input  logic                     valid_i,
    input  logic                     ovf_i,
    output host_cmd_t                cmd_o,
    output logic [FRAC_W-1:0]        coef_o,
    output logic signed [ACC_W-1:0]  init_o,
    output logic [STEP_W-1:0]        target_o
);
    logic                    run_q;
    logic [FRAC_W-1:0]       coef_q;
    logic signed [ACC_W-1:0] init_q;
    logic [STEP_W-1:0]       target_q;
    logic                    sel_ctrl, sel_coef, sel_init, sel_target;
    logic                    unused_wdata;

    // Address decode for writes.
    always_comb begin
        sel_ctrl   = (addr_i == ADDR_W'(ADR_CTRL));
        sel_coef   = (addr_i == ADDR_W'(ADR_COEF));
        sel_init   = (addr_i == ADDR_W'(ADR_INIT));
        sel_target = (addr_i == ADDR_W'(ADR_TARGET));
    end

    // Write-side storage of host fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            coef_q   <= '0;
            init_q   <= '0;
            target_q <= '0;
        end else if (wr_en_i) begin
            if (sel_ctrl)   run_q    <= wdata_i[CB_RUN];
            if (sel_coef)   coef_q   <= wdata_i[FRAC_W-1:0];
            if (sel_init)   init_q   <= wdata_i[ACC_W-1:0];
            if (sel_target) target_q <= wdata_i[STEP_W-1:0];
        end
    end

    // Self-clearing strobes: valid only in the cycle of the write.
    always_comb begin
        cmd_o.run  = run_q;
        cmd_o.load = wr_en_i && sel_ctrl && wdata_i[CB_LOAD];
        cmd_o.ack  = wr_en_i && sel_ctrl && wdata_i[CB_ACK];
    end

    assign coef_o   = coef_q;
    assign init_o   = init_q;
    assign target_o = target_q;
    assign unused_wdata = ^wdata_i;

    // Read mux over the full address.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADR_CTRL))        rdata_o[CB_RUN] = run_q;
        else if (addr_i == ADDR_W'(ADR_COEF))   rdata_o = 32'(coef_q);
        else if (addr_i == ADDR_W'(ADR_INIT))   rdata_o = 32'(init_q);
        else if (addr_i == ADDR_W'(ADR_RESULT)) rdata_o = 32'(integral_i);
        else if (addr_i == ADDR_W'(ADR_STATUS)) begin
            rdata_o[SB_VALID] = valid_i;
            rdata_o[SB_OVF]   = ovf_i;
        end
        else if (addr_i == ADDR_W'(ADR_TARGET)) rdata_o = 32'(target_q);
    end

    // R9: a coefficient write is what the datapath sees on the next cycle.
    a_r9_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_coef) |=> (coef_o == $past(wdata_i[FRAC_W-1:0])));

    // R9: the run bit follows a control write.
    a_r9_run_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_ctrl) |=> (cmd_o.run == $past(wdata_i[CB_RUN])));
endmodule

// File: rtl/dda_core.sv
`timescale 1ns/1ps
// Module dda_core
// Fixed-point integration datapath: integral I (signed, ACC_W bits) plus
// residue F (unsigned, FRAC_W bits). Each step adds K*S exactly, saturates
// I at its limits and emits a pulse when I changes.
// Assumes ACC_W > SAMPLE_W + 1 and ACC_W <= 32.
module dda_core #(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 16,
    parameter int ACC_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_i,
    input  logic                       load_i,
    input  logic [FRAC_W-1:0]          coef_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [ACC_W-1:0]    init_i,
    output logic signed [ACC_W-1:0]    integral_o,
    output logic                       ovf_o,
    output logic                       pulse_o,
    output logic                       pulse_dn_o
);
    localparam int PW = SAMPLE_W + FRAC_W + 1;
    localparam int SW = PW + 1;
    localparam int DW = SW - FRAC_W;
    localparam int TW = ACC_W + DW + 1;
    localparam logic signed [ACC_W-1:0] I_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] I_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [TW-1:0]    T_MAX = TW'(I_MAX);
    localparam logic signed [TW-1:0]    T_MIN = TW'(I_MIN);

    logic signed [ACC_W-1:0] int_q, int_nxt;
    logic [FRAC_W-1:0]       res_q, res_nxt;
    logic                    ovf_q, pulse_q, dn_q;
    logic signed [PW-1:0]    prod;
    logic signed [SW-1:0]    sum;
    logic signed [DW-1:0]    carry;
    logic signed [TW-1:0]    trial;
    logic                    sat_hi, sat_lo;

    // Exact product, residue add, and split into carry and new residue.
    always_comb begin
        prod  = sample_i * $signed({1'b0, coef_i});
        sum   = SW'(prod) + $signed({{(SW-FRAC_W){1'b0}}, res_q});
        carry = DW'(sum >>> FRAC_W);
        trial = TW'(int_q) + TW'(carry);
    end

    // Saturation of the integer part; residue frozen while clamped.
    always_comb begin
        sat_hi = (trial > T_MAX);
        sat_lo = (trial < T_MIN);
        if (sat_hi) begin
            int_nxt = I_MAX;
            res_nxt = res_q;
        end else if (sat_lo) begin
            int_nxt = I_MIN;
            res_nxt = res_q;
        end else begin
            int_nxt = ACC_W'(trial);
            res_nxt = sum[FRAC_W-1:0];
        end
    end

    // State update: load first, then step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q   <= '0;
            res_q   <= '0;
            ovf_q   <= 1'b0;
            pulse_q <= 1'b0;
            dn_q    <= 1'b0;
        end else if (load_i) begin
            int_q   <= init_i;
            res_q   <= '0;
            ovf_q   <= 1'b0;
            pulse_q <= 1'b0;
            dn_q    <= 1'b0;
        end else if (step_i) begin
            int_q   <= int_nxt;
            res_q   <= res_nxt;
            ovf_q   <= ovf_q | sat_hi | sat_lo;
            pulse_q <= (int_nxt != int_q);
            dn_q    <= (int_nxt < int_q);
        end else begin
            pulse_q <= 1'b0;
            dn_q    <= 1'b0;
        end
    end

    assign integral_o = int_q;
    assign ovf_o      = ovf_q;
    assign pulse_o    = pulse_q;
    assign pulse_dn_o = dn_q;

    // R3: a load installs the initial value with an empty residue and no pulse.
    a_r3_load_installs: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (int_q == $past(init_i) && res_q == '0 && !pulse_q));

    // R4: without a step or load the state is frozen and no pulse appears.
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> ($stable(int_q) && $stable(res_q) && !pulse_q));

    // R5: a pulse always comes with a change of the integral.
    a_r5_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (int_q != $past(int_q)));

    // R5: a down pulse marks a decrease.
    a_r5_down_is_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        dn_q |-> (pulse_q && int_q < $past(int_q)));

    // R6: the overflow flag is sticky until a load.
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !load_i) |=> ovf_q);
endmodule

// File: rtl/dda_step_ctr.sv
`timescale 1ns/1ps
// Module dda_step_ctr
// Counts integration steps and raises a sticky valid flag each time the
// count reaches a nonzero target, restarting the count. Assumes the target
// is stable while counting; a target of 0 disables the flag.
module dda_step_ctr #(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              load_i,
    input  logic              ack_i,
    input  logic [STEP_W-1:0] target_i,
    output logic              valid_o
);
    logic [STEP_W-1:0] cnt_q, cnt_inc;
    logic              valid_q, hit;

    // Target comparison on the incremented count.
    always_comb begin
        cnt_inc = cnt_q + STEP_W'(1);
        hit     = step_i && !load_i && (target_i != '0) && (cnt_inc == target_i);
    end

    // Step count: cleared by load, restarted by a hit.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) cnt_q <= '0;
        else if (hit)         cnt_q <= '0;
        else if (step_i)      cnt_q <= cnt_inc;
    end

    // Valid flag: a hit wins over an acknowledge at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) valid_q <= 1'b0;
        else if (hit)         valid_q <= 1'b1;
        else if (ack_i)       valid_q <= 1'b0;
    end

    assign valid_o = valid_q;

    // R7: the flag stays up until acknowledged or reloaded.
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ack_i && !load_i) |=> valid_q);

    // R8: an acknowledge without a step always clears the flag.
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !step_i) |=> !valid_q);
endmodule

// File: rtl/dda_integrator.sv
`timescale 1ns/1ps
// Module dda_integrator
// Top of the scaled integrator: register file, integration datapath and
// step counter on one clock. Assumes ACC_W <= 32 and ACC_W > SAMPLE_W + 1.
module dda_integrator
    import dda_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 16,
    parameter int ACC_W    = 32,
    parameter int STEP_W   = 16,
    parameter int ADDR_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr_en,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic                       pulse_o,
    output logic                       pulse_dn_o,
    output logic                       irq_o
);
    host_cmd_t               cmd;
    logic [FRAC_W-1:0]       coef;
    logic signed [ACC_W-1:0] init_val, integral;
    logic [STEP_W-1:0]       target;
    logic                    valid, ovf, step;

    // A step happens on every enabled cycle that is not a load.
    assign step  = cmd.run && !cmd.load;
    assign irq_o = valid;

    dda_regs #(
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W),
        .ACC_W  (ACC_W),
        .STEP_W (STEP_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wr_en_i    (reg_wr_en),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .integral_i (integral),
        .valid_i    (valid),
        .ovf_i      (ovf),
        .cmd_o      (cmd),
        .coef_o     (coef),
        .init_o     (init_val),
        .target_o   (target)
    );

    dda_core #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_W   (FRAC_W),
        .ACC_W    (ACC_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .load_i     (cmd.load),
        .coef_i     (coef),
        .sample_i   (sample_i),
        .init_i     (init_val),
        .integral_o (integral),
        .ovf_o      (ovf),
        .pulse_o    (pulse_o),
        .pulse_dn_o (pulse_dn_o)
    );

    dda_step_ctr #(
        .STEP_W (STEP_W)
    ) u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .load_i   (cmd.load),
        .ack_i    (cmd.ack),
        .target_i (target),
        .valid_o  (valid)
    );

    // R1: nothing is signalled in the cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!pulse_o && !pulse_dn_o && !irq_o));
endmodule

// File: tb/tb_dda_integrator.sv
`timescale 1ns/1ps
module tb_dda_integrator;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 6;
    localparam int FW = 8;
    localparam int AW = 12;
    localparam int TW = 8;
    localparam int ADW = 5;
    localparam int IMAX = (1 << (AW-1)) - 1;
    localparam int IMIN = -(1 << (AW-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [SW-1:0] sample_i = '0;
    logic [ADW-1:0] reg_addr = '0;
    logic reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic pulse_o, pulse_dn_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_acc, m_res, m_k, m_cnt, m_tgt;
    bit m_valid, m_ovf, m_pulse, m_dn;

    always #(CLK_PERIOD/2) clk = ~clk;

    dda_integrator #(
        .SAMPLE_W (SW), .FRAC_W (FW), .ACC_W (AW), .STEP_W (TW), .ADDR_W (ADW)
    ) dut (
        .clk (clk), .rst_n (rst_n), .sample_i (sample_i),
        .reg_addr (reg_addr), .reg_wr_en (reg_wr_en), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .pulse_o (pulse_o), .pulse_dn_o (pulse_dn_o),
        .irq_o (irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input int addr, output int v);
        reg_addr = ADW'(addr);
        #1;
        v = int'($signed(reg_rdata));
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_addr  = ADW'(addr);
        reg_wdata = 32'(data);
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Arithmetic model of one step, from the requirement formulas.
    task automatic model_step(input int s, input bit ack);
        int sum, carry, trial, old, nc;
        bit hit;
        old   = m_acc;
        sum   = m_res + s * m_k;
        carry = sum >>> FW;
        trial = m_acc + carry;
        if (trial > IMAX) begin
            m_acc = IMAX; m_ovf = 1'b1;
        end else if (trial < IMIN) begin
            m_acc = IMIN; m_ovf = 1'b1;
        end else begin
            m_acc = trial; m_res = sum & ((1 << FW) - 1);
        end
        m_pulse = (m_acc != old);
        m_dn    = (m_acc < old);
        nc  = (m_cnt + 1) & ((1 << TW) - 1);
        hit = (m_tgt != 0) && (nc == m_tgt);
        m_cnt = hit ? 0 : nc;
        if (hit) m_valid = 1'b1;
        else if (ack) m_valid = 1'b0;
    endtask

    task automatic start_run(input int k, input int init, input int tgt, input bit go);
        int v;
        wr('h00, 2);
        wr('h04, k);
        wr('h08, init);
        wr('h14, tgt);
        wr('h00, 2);
        m_k = k & ((1 << FW) - 1); m_acc = init; m_res = 0; m_cnt = 0;
        m_tgt = tgt; m_valid = 1'b0; m_ovf = 1'b0;
        rd('h0C, v); check("R3 load value", v, init);
        rd('h10, v); check("R3 load clears status", v, 0);
        rd('h00, v); check("R3 load bit reads 0", v, 0);
        if (go) wr('h00, 1);
    endtask

    function automatic int pick(input int mode, input int i, input int c);
        if (mode == 0) return (i % 64) - 32;
        if (mode == 2) return ((i * 13 + 5) % 64) - 32;
        return c;
    endfunction

    task automatic run(input int n, input int mode, input int c, input int ack_at, input string tag);
        int v, s;
        for (int i = 0; i < n; i++) begin
            s = pick(mode, i, c);
            sample_i = SW'(s);
            if (i == ack_at) begin
                reg_addr = ADW'('h00); reg_wdata = 32'd5; reg_wr_en = 1'b1;
            end
            @(negedge clk);
            reg_wr_en = 1'b0;
            model_step(s, i == ack_at);
            rd('h0C, v); check(tag, v, m_acc);
            check("R5 pulse", int'(pulse_o), int'(m_pulse));
            check("R5 pulse_dn", int'(pulse_dn_o), int'(m_dn));
            check("R7 irq", int'(irq_o), int'(m_valid));
            rd('h10, v); check("R6 R7 status", v, (int'(m_ovf) << 1) | int'(m_valid));
        end
        sample_i = '0;
    endtask

    initial begin
        int v;
        int klist[6] = '{0, 1, 37, 128, 200, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 'h18; a += 4) begin
            rd(a, v); check("R1 reset register", v, 0);
        end
        check("R1 pulse", int'(pulse_o), 0);
        check("R1 irq", int'(irq_o), 0);

        // R9: readback and field widths
        wr('h04, 32'hFFFF_FF5A); rd('h04, v); check("R9 coef field", v, 'h5A);
        wr('h08, 'h0FF0);        rd('h08, v); check("R9 init sign extend", v, -16);
        wr('h14, 'h1234);        rd('h14, v); check("R9 target field", v, 'h34);
        wr('h00, 1);             rd('h00, v); check("R9 run bit", v, 1);
        rd('h18, v); check("R9 unmapped", v, 0);
        rd('h06, v); check("R9 unaligned", v, 0);

        // R4: disabled integrator ignores the sample
        start_run(100, 50, 0, 1'b0);
        sample_i = SW'(17);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd('h0C, v); check("R4 hold integral", v, 50);
            check("R4 no pulse", int'(pulse_o), 0);
        end
        sample_i = '0;

        // R2 R5: full sample sweep across coefficients
        foreach (klist[j]) begin
            start_run(klist[j], 0, 0, 1'b1);
            run(64, 0, 0, -1, "R2 sweep");
        end
        foreach (klist[j]) begin
            start_run(klist[j], -300, 0, 1'b1);
            run(64, 2, 0, -1, "R2 scrambled");
        end
        // R5: slow rate, one LSB per four steps
        start_run(64, 0, 0, 1'b1);
        run(16, 1, 1, -1, "R5 rate");

        // R6: saturation both ways, flag sticky
        start_run(255, 2030, 0, 1'b1);
        run(12, 1, 31, -1, "R6 saturate high");
        run(6, 1, -32, -1, "R6 leave high limit");
        start_run(255, -2030, 0, 1'b1);
        run(12, 1, -32, -1, "R6 saturate low");

        // R7 R8: target hits, acknowledge, hit wins over acknowledge
        start_run(128, 0, 5, 1'b1);
        run(12, 1, 3, 7, "R7 R8 target and ack");
        start_run(128, 0, 4, 1'b1);
        run(8, 1, 1, 3, "R8 hit beats ack");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule